// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block generates the raster timing for a parallel LCD panel: horizontal sync, vertical sync, a data-enable strobe, the current pixel column and line, and a one-cycle pulse at the start of vertical blanking that can feed an interrupt controller. Software sets it up through a narrow register write port. Each timing field holds its quantity minus one. Horizontal quantities count in characters of eight pixel clocks. Vertical quantities count in lines.

The raster advances only on cycles where the pixel-clock enable is high, so one system clock can drive panels of many dot rates. Timing and polarity writes go to a pending copy. That copy moves into the working copy only while the display is off or at the moment the raster wraps back to its first pixel, so no frame ever mixes two timings. The block has no data stream, so every port is a plain control or status signal and nothing needs back-pressure.

Register map, 16-bit, by `cfg_addr`: 0 control (bit 0 display on, bit 1 blank-interrupt enable, bit 2 horizontal sync active-low, bit 3 vertical sync active-low); 1 horizontal count (bits 7:0 total characters − 1, bits 15:8 visible characters − 1); 2 visible lines − 1; 3 total lines − 1; 4 horizontal sync (bits 11:0 start character − 1, bits 15:12 width in characters − 1); 5 vertical sync (bits 11:0 start line − 1, bits 15:12 width in lines − 1). Writes to addresses 6 and 7 are dropped.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset every register reads as zero, the display is off, both counters are zero and hsync, vsync, data-enable and the blank pulse are all low.
- R2: While on, the column advances by one on each cycle with `pix_en` high and holds otherwise. After column (H+1)·8−1, where H is horizontal count bits 7:0, it returns to 0 and the line advances. After line VT, the total-lines field, the line returns to 0.
- R3: Data-enable is high exactly when the display is on, the column is below (D+1)·8, where D is horizontal count bits 15:8, and the line is at most the visible-lines field.
- R4: Horizontal sync is asserted for columns from (S+1)·8 up to but not including (S+W+2)·8. S is horizontal sync bits 11:0 and W is bits 15:12.
- R5: Vertical sync is asserted for lines from S+1 up to but not including S+W+2. S is vertical sync bits 11:0 and W is bits 15:12.
- R6: Control bit 2 makes the horizontal sync pin active-low and control bit 3 does the same for vertical sync. A clear bit means active-high.
- R7: `vblank_irq` is high for exactly the one enabled cycle on which column 0 of line (visible-lines field + 1) is shown, and only when the display and the interrupt enable are both on.
- R8: Timing and polarity writes made while the display is on take effect at the next raster wrap. Display-on and interrupt-enable take effect on the cycle after the write.
- R9: While the display is off, both counters stay at zero, data-enable and the blank pulse stay low, and each sync pin sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| pix_en | input | 1 | Pixel-clock enable |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 2 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 3 |
| de_o | output | 1 | Data-enable for the visible area |
| pix_x | output | X_W | Current column in pixels |
| pix_y | output | Y_W | Current line |
| vblank_irq | output | 1 | Start-of-vertical-blank pulse |

## Verification
The embedded properties check on every cycle that the counters hold while stalled or off, that the column never passes its programmed last value, and that the working configuration changes only when a load is allowed. They also check that the blank pulse never lasts two cycles and that the outputs stay quiet while the display is off. Only the bench's scenarios can show the exact sync and data-enable windows, the polarity inversion, the deferred timing change across a frame boundary, and the pulse appearing on the correct line. The bench shows these by comparing every output against a behavioural raster model under full-rate and irregular pixel enables.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned TG_DW = 16;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_HCNT  = 3'd1,
    REG_VDISP = 3'd2,
    REG_VTOT  = 3'd3,
    REG_HSYNC = 3'd4,
    REG_VSYNC = 3'd5
  } tg_addr_e;

  typedef struct packed {
    logic [TG_DW-1:0] hcount;
    logic [TG_DW-1:0] vdisp;
    logic [TG_DW-1:0] vtotal;
    logic [TG_DW-1:0] hsync;
    logic [TG_DW-1:0] vsync;
    logic             hpol_n;
    logic             vpol_n;
  } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TG_DW-1:0]  wdata,
  input  logic              frame_load,
  output logic              disp_on,
  output logic              irq_en,
  output tg_cfg_t           cfg_act
);
  tg_cfg_t pend_q;
  logic [TG_DW-1:0] unused_wdata;

  assign unused_wdata = wdata & 16'hFFF0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      cfg_act <= '0;
      disp_on <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (frame_load) cfg_act <= pend_q;
      if (we) begin
        case (tg_addr_e'(addr))
          REG_CTRL: begin
            disp_on       <= wdata[0];
            irq_en        <= wdata[1];
            pend_q.hpol_n <= wdata[2];
            pend_q.vpol_n <= wdata[3];
          end
          REG_HCNT:  pend_q.hcount <= wdata;
          REG_VDISP: pend_q.vdisp  <= wdata;
          REG_VTOT:  pend_q.vtotal <= wdata;
          REG_HSYNC: pend_q.hsync  <= wdata;
          REG_VSYNC: pend_q.vsync  <= wdata;
          default: ;
        endcase
      end
    end
  end

  // R8: the working copy changes only on a permitted load
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(cfg_act));
endmodule

// File: rtl/lcd_tg_counters.sv
module lcd_tg_counters #(
  parameter int unsigned X_W   = 12,
  parameter int unsigned Y_W   = 12,
  parameter int unsigned CMP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pix_en,
  input  logic [CMP_W-1:0] h_last,
  input  logic [CMP_W-1:0] v_last,
  output logic [X_W-1:0]   h,
  output logic [Y_W-1:0]   v,
  output logic             frame_wrap
);
  logic h_end, v_end;

  assign h_end      = (CMP_W'(h) == h_last);
  assign v_end      = (CMP_W'(v) == v_last);
  assign frame_wrap = run & pix_en & h_end & v_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      h <= '0;
      v <= '0;
    end else if (pix_en) begin
      if (h_end) begin
        h <= '0;
        v <= v_end ? '0 : v + 1'b1;
      end else begin
        h <= h + 1'b1;
      end
    end
  end

  // R9: counters parked while off
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (h == '0) && (v == '0));
  // R2: no movement without a pixel enable
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !pix_en |=> $stable(h) && $stable(v));
  // R2: column never passes its programmed end
  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> CMP_W'(h) <= h_last);
endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
  parameter int unsigned CMP_W = 20
) (
  input  logic [CMP_W-1:0] pos,
  input  logic [CMP_W-1:0] start,
  input  logic [CMP_W-1:0] len,
  output logic             active
);
  logic [CMP_W-1:0] stop;
  assign stop   = start + len;
  assign active = (pos >= start) && (pos < stop);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned X_W    = 12,
  parameter int unsigned Y_W    = 12,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TG_DW-1:0]  cfg_wdata,
  input  logic              pix_en,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [X_W-1:0]    pix_x,
  output logic [Y_W-1:0]    pix_y,
  output logic              vblank_irq
);
  localparam int unsigned CHAR_SH = 3;
  localparam int unsigned CMP_W   = TG_DW + CHAR_SH + 1;
  localparam int unsigned N_AX    = 2;

  tg_cfg_t          cfg;
  logic             disp_on, irq_en, frame_wrap, frame_load;
  logic [CMP_W-1:0] h_last, v_last, hvis_last, x_w, y_w;
  logic [CMP_W-1:0] win_pos   [N_AX];
  logic [CMP_W-1:0] win_start [N_AX];
  logic [CMP_W-1:0] win_len   [N_AX];
  logic [N_AX-1:0]  win_act;

  assign frame_load = !disp_on || frame_wrap;

  lcd_tg_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_load(frame_load), .disp_on(disp_on), .irq_en(irq_en), .cfg_act(cfg)
  );

  assign h_last    = CMP_W'({cfg.hcount[7:0], 3'b111});
  assign hvis_last = CMP_W'({cfg.hcount[15:8], 3'b111});
  assign v_last    = CMP_W'(cfg.vtotal);

  lcd_tg_counters #(.X_W(X_W), .Y_W(Y_W), .CMP_W(CMP_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(disp_on), .pix_en(pix_en),
    .h_last(h_last), .v_last(v_last), .h(pix_x), .v(pix_y),
    .frame_wrap(frame_wrap)
  );

  assign x_w = CMP_W'(pix_x);
  assign y_w = CMP_W'(pix_y);

  always_comb begin
    win_pos[0]   = x_w;
    win_start[0] = (CMP_W'(cfg.hsync[11:0]) + 1'b1) << CHAR_SH;
    win_len[0]   = (CMP_W'(cfg.hsync[15:12]) + 1'b1) << CHAR_SH;
    win_pos[1]   = y_w;
    win_start[1] = CMP_W'(cfg.vsync[11:0]) + 1'b1;
    win_len[1]   = CMP_W'(cfg.vsync[15:12]) + 1'b1;
  end

  for (genvar i = 0; i < N_AX; i++) begin : g_sync_win
    lcd_tg_window #(.CMP_W(CMP_W)) win_i (
      .pos(win_pos[i]), .start(win_start[i]), .len(win_len[i]),
      .active(win_act[i])
    );
  end

  assign hsync_o    = (disp_on & win_act[0]) ^ cfg.hpol_n;
  assign vsync_o    = (disp_on & win_act[1]) ^ cfg.vpol_n;
  assign de_o       = disp_on && (x_w <= hvis_last) && (y_w <= CMP_W'(cfg.vdisp));
  assign vblank_irq = disp_on && irq_en && pix_en && (pix_x == '0) &&
                      (y_w == CMP_W'(cfg.vdisp) + 1'b1);

  // R7: the blank pulse lasts a single cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq);
  // R9: nothing visible while off
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> !de_o && !vblank_irq);
  // R6: idle sync level follows the polarity bits
  p_sync_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (hsync_o == cfg.hpol_n) && (vsync_o == cfg.vpol_n));
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pix_en = 1'b0;
  logic        hsync_o, vsync_o, de_o, vblank_irq;
  logic [11:0] pix_x, pix_y;

  always #10 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_en(pix_en), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y),
    .vblank_irq(vblank_irq)
  );

  int total = 0, bad = 0;
  string phase = "R1 reset";
  logic [15:0] lfsr = 16'hACE1;
  int irq_seen = 0;

  // behavioural reference model
  int p_hc, p_vd, p_vt, p_hs, p_vs, p_hp, p_vp;
  int a_hc, a_vd, a_vt, a_hs, a_vs, a_hp, a_vp;
  int m_on, m_ien, m_h, m_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_hc = 0; p_vd = 0; p_vt = 0; p_hs = 0; p_vs = 0; p_hp = 0; p_vp = 0;
      a_hc = 0; a_vd = 0; a_vt = 0; a_hs = 0; a_vs = 0; a_hp = 0; a_vp = 0;
      m_on = 0; m_ien = 0; m_h = 0; m_v = 0;
    end else begin
      automatic int last_x = (a_hc % 256) * 8 + 7;
      automatic bit wrap = m_on != 0 && pix_en && m_h == last_x && m_v == a_vt;
      automatic bit load = (m_on == 0) || wrap;
      if (m_on == 0) begin m_h = 0; m_v = 0; end
      else if (pix_en) begin
        if (m_h == last_x) begin
          m_h = 0;
          m_v = (m_v == a_vt) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
      if (load) begin
        a_hc = p_hc; a_vd = p_vd; a_vt = p_vt; a_hs = p_hs; a_vs = p_vs;
        a_hp = p_hp; a_vp = p_vp;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_on = cfg_wdata[0]; m_ien = cfg_wdata[1];
                      p_hp = cfg_wdata[2]; p_vp = cfg_wdata[3]; end
          3'd1: p_hc = cfg_wdata;
          3'd2: p_vd = cfg_wdata;
          3'd3: p_vt = cfg_wdata;
          3'd4: p_hs = cfg_wdata;
          3'd5: p_vs = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s [%s] actual=%0d expected=%0d", req, what, phase, act, exp);
    end
  endtask

  task automatic compare();
    int hs0, hsl, vs0, vsl, e_de, e_hs, e_vs, e_irq;
    hs0 = ((a_hs % 4096) + 1) * 8;
    hsl = ((a_hs / 4096) + 1) * 8;
    vs0 = (a_vs % 4096) + 1;
    vsl = (a_vs / 4096) + 1;
    e_de  = (m_on != 0 && m_h < ((a_hc / 256) + 1) * 8 && m_v <= a_vd) ? 1 : 0;
    e_hs  = ((m_on != 0 && m_h >= hs0 && m_h < hs0 + hsl) ? 1 : 0) ^ a_hp;
    e_vs  = ((m_on != 0 && m_v >= vs0 && m_v < vs0 + vsl) ? 1 : 0) ^ a_vp;
    e_irq = (m_on != 0 && m_ien != 0 && pix_en && m_h == 0 && m_v == a_vd + 1) ? 1 : 0;
    chk("R2", "pix_x", int'(pix_x), m_h);
    chk("R2", "pix_y", int'(pix_y), m_v);
    chk("R3", "de", int'(de_o), e_de);
    chk("R4", "hsync", int'(hsync_o), e_hs);
    chk("R5", "vsync", int'(vsync_o), e_vs);
    chk("R7", "irq", int'(vblank_irq), e_irq);
    if (vblank_irq) irq_seen++;
  endtask

  task automatic step(input bit pe);
    @(negedge clk);
    compare();
    cfg_we = 1'b0;
    pix_en = pe;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    compare();
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d); pix_en = 1'b1;
  endtask

  task automatic run_full(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0]);
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) step(1'b1);
    @(negedge clk);
    // R1: reset values at the ports
    chk("R1", "pix_x", int'(pix_x), 0);
    chk("R1", "pix_y", int'(pix_y), 0);
    chk("R1", "de/hs/vs/irq", int'({de_o, hsync_o, vsync_o, vblank_irq}), 0);
    rst_n = 1'b1;
    run_full(3);
    phase = "R9 off config";
    wr(1, 16'h0103); wr(2, 2); wr(3, 5); wr(4, 16'h0001); wr(5, 16'h0003);
    wr(7, 16'hFFFF); wr(6, 16'hFFFF);
    run_full(5);
    phase = "R2 full rate";
    wr(0, 16'h0003);
    run_full(420);
    phase = "R2 stalled enable";
    run_rand(600);
    phase = "R8 mid-frame change";
    run_full(37);
    wr(1, 16'h0204); wr(4, 16'h1003); wr(5, 16'h1002);
    run_full(700);
    phase = "R6 polarity";
    wr(0, 16'h000F);
    run_rand(900);
    phase = "R7 irq disabled";
    wr(0, 16'h000D);
    run_full(500);
    phase = "R9 display off";
    wr(0, 16'h000C);
    run_rand(60);
    phase = "R8 restart";
    wr(0, 16'h0003);
    run_full(400);
    // R7: the pulse must have appeared during the enabled runs
    chk("R7", "irq count>0", (irq_seen > 0) ? 1 : 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule